// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block watches a bank of level-sensitive interrupt lines and turns each unmasked low-to-high transition into one posted 32-bit memory write on a single-beat request channel. Each write goes to one of two message-address registers, picked per source by a routing register. The 32-bit word in the chosen register supplies both fields of the write. Its upper bits, with the five lowest cleared, form the target address. Its five lowest bits, zero-extended, form the payload.

Software reaches the block through a word-indexed register slave. The slave exposes the current line levels and a sticky event register; any access to the event register, read or write, empties it. It also exposes two read-only request views that split the active, unmasked lines by their routing bit. When several lines rise together, one message per line is queued and the messages leave in ascending line order. Each message is held on the channel until the receiver accepts it.

Top module: `msi_irq_agg`

## Requirements
- R1: After reset every register reads zero, and `msg_valid_o` stays low for as long as `rst_ni` is low.
- R2: The level register (index 5) shows each implemented input one clock after it is sampled, and a bit clears when its input falls.
- R3: A rising input sets its bit in the event register (index 4), and the bit stays set until the register is accessed. A read returns the current value and empties the register. A write empties it whatever the data. A rise in the same cycle as such an access is kept.
- R4: A message is issued only for a rising input whose mask bit (index 2) is 1. A line held high issues no second message. A masked rise issues none but still sets its event bit.
- R5: A routing bit (index 3) of 1 sends that line's message through address register B (index 1). A routing bit of 0 sends it through register A (index 0).
- R6: The message address is the selected register with bits 4:0 cleared. The message data is bits 4:0 of the same register, zero-extended.
- R7: View 0 (index 6) reads level AND mask AND NOT routing. View 1 (index 7) reads level AND mask AND routing.
- R8: Indices 0 to 3 read back what was written, with mask and routing truncated to 11 bits. Writes to indices 5, 6 and 7 change nothing.
- R9: Lines that rise in the same cycle each issue one message, in ascending line order.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, the message stays valid and its address and data do not change.
- R11: Line 9 is not implemented. Its input is ignored: it reads zero in the level and event registers and never issues a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 11 | Interrupt input lines, synchronous to clk_i |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_idx_i | input | 3 | Register word index (0 addr A, 1 addr B, 2 mask, 3 routing, 4 events, 5 level, 6 view 0, 7 view 1) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_idx_i |
| msg_valid_o | output | 1 | Message write request valid |
| msg_ready_i | input | 1 | Message write accepted when high with valid |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The assertions assume that the interrupt lines are already synchronous to the clock and that a register access lasts exactly one cycle. They place no limit on how `msg_ready_i` behaves. The bench changes every input on the falling edge and holds a read strobe for a single cycle. It samples read data before the following rising edge, because that edge performs the clear on the event register. Back-pressure is applied by holding ready low across several cycles of a queued burst, so the hold and ordering properties are exercised with messages waiting.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int DW    = 32;
  localparam int LOW_W = 5;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IDX_ADDR_A = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_B = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MASK   = 3'd2;
  localparam logic [IDX_W-1:0] IDX_ROUTE  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_EVENT  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_LEVEL  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_VIEW0  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_VIEW1  = 3'd7;
endpackage

// File: rtl/msi_src_capture.sv
module msi_src_capture #(
  parameter int               N_SRC     = 11,
  parameter logic [N_SRC-1:0] IMPL_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             evt_clr_i,
  output logic [N_SRC-1:0] level_o,
  output logic [N_SRC-1:0] event_o,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] lvl_q, evt_q, live;

  assign live   = irq_i & IMPL_MASK;
  assign rise_o = live & ~lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      evt_q <= '0;
    end else begin
      lvl_q <= live;
      // a rise coinciding with a clear survives
      evt_q <= (evt_clr_i ? '0 : evt_q) | rise_o;
    end
  end

  assign level_o = lvl_q;
  assign event_o = evt_q;

  assert_evt_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs import msi_agg_pkg::*; #(
  parameter int N_SRC = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] level_i,
  input  logic [N_SRC-1:0] event_i,
  output logic [DW-1:0]    addr_a_o,
  output logic [DW-1:0]    addr_b_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] route_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int N_ADDR = 2;

  logic [DW-1:0]    addr_q [N_ADDR];
  logic [N_SRC-1:0] mask_q, route_q;
  logic             wr;

  assign wr = req_i & we_i;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     addr_q[g] <= '0;
      else if (wr && idx_i == IDX_ADDR_A + IDX_W'(g))  addr_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      if (idx_i == IDX_MASK)  mask_q  <= wdata_i[N_SRC-1:0];
      if (idx_i == IDX_ROUTE) route_q <= wdata_i[N_SRC-1:0];
    end
  end

  function automatic logic [DW-1:0] zext(input logic [N_SRC-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[N_SRC-1:0] = v;
    return r;
  endfunction

  always_comb begin
    unique case (idx_i)
      IDX_ADDR_A: rdata_o = addr_q[0];
      IDX_ADDR_B: rdata_o = addr_q[1];
      IDX_MASK:   rdata_o = zext(mask_q);
      IDX_ROUTE:  rdata_o = zext(route_q);
      IDX_EVENT:  rdata_o = zext(event_i);
      IDX_LEVEL:  rdata_o = zext(level_i);
      IDX_VIEW0:  rdata_o = zext(level_i & mask_q & ~route_q);
      default:    rdata_o = zext(level_i & mask_q & route_q);
    endcase
  end

  assign addr_a_o = addr_q[0];
  assign addr_b_o = addr_q[1];
  assign mask_o   = mask_q;
  assign route_o  = route_q;
endmodule

// File: rtl/msi_msg_queue.sv
module msi_msg_queue import msi_agg_pkg::*; #(
  parameter int N_SRC = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] fire_i,
  input  logic [N_SRC-1:0] route_i,
  input  logic [DW-1:0]    addr_a_i,
  input  logic [DW-1:0]    addr_b_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [DW-1:0]    addr_o,
  output logic [DW-1:0]    data_o
);
  localparam logic [N_SRC-1:0] ONE = {{(N_SRC-1){1'b0}}, 1'b1};

  logic [N_SRC-1:0] owe_q, grant;
  logic             vld_q, load, sel_b;
  logic [DW-1:0]    base, addr_q, data_q;

  // lowest pending source wins
  assign grant = owe_q & (~owe_q + ONE);
  assign load  = (|owe_q) & (~vld_q | ready_i);
  assign sel_b = |(grant & route_i);
  assign base  = sel_b ? addr_b_i : addr_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owe_q  <= '0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      owe_q <= (owe_q & ~(load ? grant : '0)) | fire_i;
      if (load) begin
        vld_q  <= 1'b1;
        addr_q <= {base[DW-1:LOW_W], {LOW_W{1'b0}}};
        data_q <= DW'(base[LOW_W-1:0]);
      end else if (ready_i) begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign valid_o = vld_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  assert_msg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !ready_i) |=> vld_q);
  assert_msg_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !ready_i) |=> ($stable(addr_q) && $stable(data_q)));
  assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg import msi_agg_pkg::*; #(
  parameter int               N_SRC     = 11,
  parameter logic [N_SRC-1:0] IMPL_MASK = 11'h5FF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             msg_valid_o,
  input  logic             msg_ready_i,
  output logic [DW-1:0]    msg_addr_o,
  output logic [DW-1:0]    msg_data_o
);
  logic [N_SRC-1:0] level, evts, rise, mask, route;
  logic [DW-1:0]    addr_a, addr_b;
  logic             evt_clr;

  assign evt_clr = reg_req_i & (reg_idx_i == IDX_EVENT);

  msi_src_capture #(.N_SRC(N_SRC), .IMPL_MASK(IMPL_MASK)) u_cap (
    .clk_i, .rst_ni, .irq_i,
    .evt_clr_i (evt_clr),
    .level_o   (level),
    .event_o   (evts),
    .rise_o    (rise)
  );

  msi_cfg_regs #(.N_SRC(N_SRC)) u_regs (
    .clk_i, .rst_ni,
    .req_i    (reg_req_i),
    .we_i     (reg_we_i),
    .idx_i    (reg_idx_i),
    .wdata_i  (reg_wdata_i),
    .level_i  (level),
    .event_i  (evts),
    .addr_a_o (addr_a),
    .addr_b_o (addr_b),
    .mask_o   (mask),
    .route_o  (route),
    .rdata_o  (reg_rdata_o)
  );

  msi_msg_queue #(.N_SRC(N_SRC)) u_queue (
    .clk_i, .rst_ni,
    .fire_i   (rise & mask),
    .route_i  (route),
    .addr_a_i (addr_a),
    .addr_b_i (addr_b),
    .ready_i  (msg_ready_i),
    .valid_o  (msg_valid_o),
    .addr_o   (msg_addr_o),
    .data_o   (msg_data_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_idle_in_reset_R1: assert (!msg_valid_o);
    end
  end
endmodule

// File: tb/msi_irq_agg_test.sv
`timescale 1ns/1ps
module msi_irq_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        msg_valid, ready = 1'b1;
  logic [31:0] msg_addr, msg_data;

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] REG_A = 32'h8000_0023;
  localparam logic [31:0] REG_B = 32'h4000_105F;
  localparam logic [31:0] MA_A = 32'h8000_0020, MD_A = 32'h3;
  localparam logic [31:0] MA_B = 32'h4000_1040, MD_B = 32'h1F;

  always #2.5 clk = ~clk;

  msi_irq_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_req_i(req), .reg_we_i(we), .reg_idx_i(idx),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(msg_valid), .msg_ready_i(ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  task automatic chk(input string req_tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; idx = i;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] i, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(i, d);
    chk(tag, $sformatf("reg[%0d]", i), d, exp);
  endtask

  task automatic expect_msg(input string tag, input logic [31:0] ea, input logic [31:0] ed);
    int n = 0;
    while (!msg_valid && n < 20) begin @(negedge clk); n++; end
    chk(tag, "msg valid", {31'b0, msg_valid}, 32'h1);
    chk(tag, "msg addr", msg_addr, ea);
    chk(tag, "msg data", msg_data, ed);
    @(negedge clk);
  endtask

  task automatic expect_no_msg(input string tag, input int cycles);
    logic seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(tag, "no message", {31'b0, seen}, 32'h0);
  endtask

  task automatic t_reset;
    logic seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk("R1", "valid in reset", {31'b0, seen}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) read_chk("R1", 3'(i), 32'h0);
  endtask

  task automatic t_rw;
    reg_write(3'd0, REG_A);
    reg_write(3'd1, REG_B);
    reg_write(3'd2, 32'hFFFF_FFFF);
    reg_write(3'd3, 32'h0);
    read_chk("R8", 3'd0, REG_A);
    read_chk("R8", 3'd1, REG_B);
    read_chk("R8", 3'd2, 32'h7FF);
    read_chk("R8", 3'd3, 32'h0);
  endtask

  task automatic t_single;
    @(negedge clk); irq[2] = 1'b1;
    expect_msg("R6", MA_A, MD_A);
    read_chk("R2", 3'd5, 32'h4);
    read_chk("R3", 3'd4, 32'h4);
    read_chk("R3", 3'd4, 32'h0);
    expect_no_msg("R4", 6);
    irq[2] = 1'b0;
    @(negedge clk);
    read_chk("R2", 3'd5, 32'h0);
    read_chk("R3", 3'd4, 32'h0);
  endtask

  task automatic t_masked;
    reg_write(3'd2, 32'h7F7);
    @(negedge clk); irq[3] = 1'b1;
    expect_no_msg("R4", 6);
    read_chk("R4", 3'd4, 32'h8);
    irq[3] = 1'b0;
    @(negedge clk); irq[3] = 1'b1;
    @(negedge clk);
    reg_write(3'd4, 32'h0);
    read_chk("R3", 3'd4, 32'h0);
    irq[3] = 1'b0;
    reg_write(3'd2, 32'h7FF);
  endtask

  task automatic t_route;
    reg_write(3'd3, 32'h400);
    @(negedge clk); irq[10] = 1'b1;
    expect_msg("R5", MA_B, MD_B);
    irq[0] = 1'b1;
    expect_msg("R5", MA_A, MD_A);
    read_chk("R7", 3'd6, 32'h001);
    read_chk("R7", 3'd7, 32'h400);
    reg_write(3'd5, 32'hFFFF_FFFF);
    reg_write(3'd6, 32'hFFFF_FFFF);
    reg_write(3'd7, 32'h0);
    read_chk("R8", 3'd5, 32'h401);
    read_chk("R8", 3'd6, 32'h001);
    read_chk("R8", 3'd7, 32'h400);
    irq[0] = 1'b0; irq[10] = 1'b0;
    @(negedge clk);
    read_chk("R7", 3'd7, 32'h0);
    reg_write(3'd3, 32'h0);
    reg_write(3'd4, 32'h0);
  endtask

  task automatic t_multi;
    logic [31:0] a0;
    reg_write(3'd3, 32'h002);
    ready = 1'b0;
    @(negedge clk);
    irq[1] = 1'b1; irq[4] = 1'b1; irq[7] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "valid while stalled", {31'b0, msg_valid}, 32'h1);
    a0 = msg_addr;
    chk("R9", "first queued addr", a0, MA_B);
    repeat (3) @(negedge clk);
    chk("R10", "held valid", {31'b0, msg_valid}, 32'h1);
    chk("R10", "held addr", msg_addr, a0);
    chk("R10", "held data", msg_data, MD_B);
    ready = 1'b1;
    expect_msg("R9", MA_B, MD_B);
    expect_msg("R9", MA_A, MD_A);
    expect_msg("R9", MA_A, MD_A);
    expect_no_msg("R9", 5);
    irq[1] = 1'b0; irq[4] = 1'b0; irq[7] = 1'b0;
    reg_write(3'd3, 32'h0);
    read_chk("R3", 3'd4, 32'h092);
  endtask

  task automatic t_unimpl;
    @(negedge clk); irq[9] = 1'b1;
    expect_no_msg("R11", 6);
    read_chk("R11", 3'd5, 32'h0);
    read_chk("R11", 3'd4, 32'h0);
    irq[9] = 1'b0;
  endtask

  task automatic t_coincide;
    logic [31:0] d;
    @(negedge clk);
    irq[5] = 1'b1;
    req = 1'b1; we = 1'b0; idx = 3'd4;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
    chk("R3", "read before rise", d, 32'h0);
    expect_msg("R3", MA_A, MD_A);
    read_chk("R3", 3'd4, 32'h20);
    irq[5] = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_rw();
    t_single();
    t_masked();
    t_route();
    t_multi();
    t_unimpl();
    t_coincide();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule